// File: doc/BRIEF.md
# Card Presence Monitor

This block watches the active-low card-detect contact of a removable card socket and turns it into status a host controller can use. It resynchronises the raw contact into the local clock domain and reports it undebounced as a presence level. It then filters that level against a slow timebase tick. A qualifier shows whether the filtered view has settled, and a debounced inserted flag holds the accepted state of the socket.

When the accepted state changes, the block raises an insertion or a removal status flag. Each flag is raised only if its own status-enable input is set. Both flags are sticky until software clears them with a write-one pulse. A second set of enables selects which raised flags drive the single interrupt request.

A software full reset clears the two event flags but leaves the filter state alone. The write-protect contact level is passed straight through as a status bit. Only the power-on reset returns the whole block to its initial state.

Top module: `card_presence_monitor`

## Requirements
- R1: `raw_present` is the inverse of `cd_pin_n` after a two-flop synchroniser. A pin change made before clock edge k shows at `raw_present` after edge k+1: low pin means 1 (present), high pin means 0 (absent).
- R2: While `rst_n` is low, `stable`, `inserted`, `sts_ins`, `sts_rem` and `irq` are all 0.
- R3: `inserted` takes a new value, and `stable` rises, only after `raw_present` has held one value for `DEBOUNCE_TICKS` clock cycles in which `deb_tick` was 1. Cycles with `deb_tick` low do not advance the count.
- R4: Any change of `raw_present` drops `stable` on the next edge and restarts the count. A glitch that returns to the accepted level leaves `inserted` unchanged and raises no event.
- R5: `stable`=1 with `inserted`=0 means no card; `stable`=1 with `inserted`=1 means a card is present.
- R6: One cycle after `inserted` goes 0 to 1, `sts_ins` is set if `en_sts_ins` was 1 in the cycle of the change; otherwise it is not set.
- R7: One cycle after `inserted` goes 1 to 0, `sts_rem` is set if `en_sts_rem` was 1 in the cycle of the change; otherwise it is not set.
- R8: `sts_ins` and `sts_rem` stay set until a one-cycle pulse on `clr_ins` or `clr_rem` respectively clears them. If a set and a clear of the same flag fall in the same cycle, the set wins.
- R9: `irq` is 1 exactly when (`sts_ins` and `en_irq_ins`) or (`sts_rem` and `en_irq_rem`) holds, with no extra cycle of delay.
- R10: A `sw_rst` pulse clears `sts_ins` and `sts_rem` on the next edge. It does not change `stable` or `inserted`, and it does not disturb an ongoing debounce count.
- R11: `wp_level` follows `wp_pin` combinationally: 1 means write enabled, 0 means write protected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sw_rst | input | 1 | Software full reset pulse; clears only the event flags |
| deb_tick | input | 1 | Debounce timebase enable, one cycle per tick |
| cd_pin_n | input | 1 | Raw card-detect contact, low when a card is in |
| wp_pin | input | 1 | Raw write-protect contact |
| en_sts_ins | input | 1 | Status enable for the insertion flag |
| en_sts_rem | input | 1 | Status enable for the removal flag |
| en_irq_ins | input | 1 | Interrupt enable for the insertion flag |
| en_irq_rem | input | 1 | Interrupt enable for the removal flag |
| clr_ins | input | 1 | Write-one-to-clear pulse for the insertion flag |
| clr_rem | input | 1 | Write-one-to-clear pulse for the removal flag |
| raw_present | output | 1 | Synchronised, undebounced presence level |
| stable | output | 1 | Debounced state has settled |
| inserted | output | 1 | Debounced presence |
| wp_level | output | 1 | Write-protect contact level |
| sts_ins | output | 1 | Sticky insertion event flag |
| sts_rem | output | 1 | Sticky removal event flag |
| irq | output | 1 | Interrupt request |

## Verification
A card-detect change applied before edge k reaches `raw_present` after edge k+1. `stable` drops after edge k+2. With `deb_tick` held high, `stable` and `inserted` settle after edge k+2+`DEBOUNCE_TICKS`, and the event flag follows one edge later. `irq` and `wp_level` follow their inputs in the same cycle. The bench drives every input and samples every output on the falling clock edge. It counts falling edges from each stimulus to the edge where a result is due, and checks the cycle just before each transition as well as the transition itself. Tick gating, glitch rejection, set-versus-clear collisions and the software reset mid-count are each checked at their exact cycles.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  localparam int NUM_EVT = 2;
  localparam int EVT_INS = 0;
  localparam int EVT_REM = 1;
  typedef logic [NUM_EVT-1:0] evt_vec_t;
endpackage

// File: rtl/cpm_sync.sv
module cpm_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RESET_VAL;
        else if (g == 0) chain[g] <= d;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cpm_debounce.sv
module cpm_debounce #(
  parameter int DEBOUNCE_TICKS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic level,
  output logic settled,
  output logic accepted,
  output logic rise_pulse,
  output logic fall_pulse
);
  localparam int CW = (DEBOUNCE_TICKS > 1) ? $clog2(DEBOUNCE_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_TICKS - 1);

  logic          cand;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand       <= 1'b0;
      cnt        <= '0;
      settled    <= 1'b0;
      accepted   <= 1'b0;
      rise_pulse <= 1'b0;
      fall_pulse <= 1'b0;
    end else begin
      rise_pulse <= 1'b0;
      fall_pulse <= 1'b0;
      if (level != cand) begin
        cand    <= level;
        cnt     <= '0;
        settled <= 1'b0;
      end else if (tick && !settled) begin
        if (cnt == LAST) begin
          settled <= 1'b1;
          cnt     <= '0;
          if (cand != accepted) begin
            accepted   <= cand;
            rise_pulse <= cand;
            fall_pulse <= !cand;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cpm_evt_flags.sv
module cpm_evt_flags
  import cpm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sw_rst,
  input  evt_vec_t pulse,
  input  evt_vec_t sts_en,
  input  evt_vec_t irq_en,
  input  evt_vec_t clr,
  output evt_vec_t sts,
  output logic     irq
);
  evt_vec_t hit;

  genvar g;
  generate
    for (g = 0; g < NUM_EVT; g++) begin : g_evt
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      sts[g] <= 1'b0;
        else if (sw_rst)                 sts[g] <= 1'b0;
        else if (pulse[g] && sts_en[g])  sts[g] <= 1'b1;
        else if (clr[g])                 sts[g] <= 1'b0;
      end
      assign hit[g] = sts[g] & irq_en[g];
    end
  endgenerate

  assign irq = |hit;
endmodule

// File: rtl/card_presence_monitor.sv
module card_presence_monitor
  import cpm_pkg::*;
#(
  parameter int DEBOUNCE_TICKS = 1000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_rst,
  input  logic deb_tick,
  input  logic cd_pin_n,
  input  logic wp_pin,
  input  logic en_sts_ins,
  input  logic en_sts_rem,
  input  logic en_irq_ins,
  input  logic en_irq_rem,
  input  logic clr_ins,
  input  logic clr_rem,
  output logic raw_present,
  output logic stable,
  output logic inserted,
  output logic wp_level,
  output logic sts_ins,
  output logic sts_rem,
  output logic irq
);
  logic     cd_sync_n;
  logic     rise_p, fall_p;
  evt_vec_t pulse_v, sts_en_v, irq_en_v, clr_v, sts_v;

  cpm_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cd_pin_n), .q(cd_sync_n)
  );

  assign raw_present = ~cd_sync_n;

  cpm_debounce #(.DEBOUNCE_TICKS(DEBOUNCE_TICKS)) u_deb (
    .clk(clk), .rst_n(rst_n), .tick(deb_tick), .level(raw_present),
    .settled(stable), .accepted(inserted),
    .rise_pulse(rise_p), .fall_pulse(fall_p)
  );

  always_comb begin
    pulse_v           = '0;
    sts_en_v          = '0;
    irq_en_v          = '0;
    clr_v             = '0;
    pulse_v[EVT_INS]  = rise_p;
    pulse_v[EVT_REM]  = fall_p;
    sts_en_v[EVT_INS] = en_sts_ins;
    sts_en_v[EVT_REM] = en_sts_rem;
    irq_en_v[EVT_INS] = en_irq_ins;
    irq_en_v[EVT_REM] = en_irq_rem;
    clr_v[EVT_INS]    = clr_ins;
    clr_v[EVT_REM]    = clr_rem;
  end

  cpm_evt_flags u_evt (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .pulse(pulse_v),
    .sts_en(sts_en_v), .irq_en(irq_en_v), .clr(clr_v),
    .sts(sts_v), .irq(irq)
  );

  assign sts_ins  = sts_v[EVT_INS];
  assign sts_rem  = sts_v[EVT_REM];
  assign wp_level = wp_pin;
endmodule

// File: rtl/cpm_checker.sv
module cpm_checker (
  input logic clk,
  input logic rst_n,
  input logic sw_rst,
  input logic cd_pin_n,
  input logic en_sts_ins,
  input logic en_sts_rem,
  input logic raw_present,
  input logic stable,
  input logic inserted,
  input logic sts_ins,
  input logic sts_rem,
  input logic irq
);
  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  a_r1_raw_follows_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (raw_present == !$past(cd_pin_n, 2)));

  a_r3_accept_only_when_settling: assert property (@(posedge clk) disable iff (!rst_n)
    (inserted != $past(inserted)) |-> (stable && !$past(stable)));

  a_r4_change_drops_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_present != $past(raw_present)) |=> !stable);

  a_r6_insert_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(inserted) && en_sts_ins && !sw_rst) |=> sts_ins);

  a_r7_remove_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(inserted) && en_sts_rem && !sw_rst) |=> sts_rem);

  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts_ins && !sts_rem) |-> !irq);
endmodule

bind card_presence_monitor cpm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .cd_pin_n(cd_pin_n),
  .en_sts_ins(en_sts_ins), .en_sts_rem(en_sts_rem),
  .raw_present(raw_present), .stable(stable), .inserted(inserted),
  .sts_ins(sts_ins), .sts_rem(sts_rem), .irq(irq)
);

// File: tb/sim_card_presence_monitor.sv
`timescale 1ns/1ps
module sim_card_presence_monitor;
  localparam int DEB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0, sw_rst = 1'b0, deb_tick = 1'b1, cd_pin_n = 1'b1, wp_pin = 1'b1;
  logic en_sts_ins = 1'b0, en_sts_rem = 1'b0, en_irq_ins = 1'b0, en_irq_rem = 1'b0;
  logic clr_ins = 1'b0, clr_rem = 1'b0;
  logic raw_present, stable, inserted, wp_level, sts_ins, sts_rem, irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  card_presence_monitor #(.DEBOUNCE_TICKS(DEB)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .deb_tick(deb_tick),
    .cd_pin_n(cd_pin_n), .wp_pin(wp_pin), .en_sts_ins(en_sts_ins),
    .en_sts_rem(en_sts_rem), .en_irq_ins(en_irq_ins), .en_irq_rem(en_irq_rem),
    .clr_ins(clr_ins), .clr_rem(clr_rem), .raw_present(raw_present),
    .stable(stable), .inserted(inserted), .wp_level(wp_level),
    .sts_ins(sts_ins), .sts_rem(sts_rem), .irq(irq)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic t_reset;
    cyc(2);
    chk("R2 stable in reset", stable, 1'b0);
    chk("R2 inserted in reset", inserted, 1'b0);
    chk("R2 sts_ins in reset", sts_ins, 1'b0);
    chk("R2 sts_rem in reset", sts_rem, 1'b0);
    chk("R2 irq in reset", irq, 1'b0);
    rst_n = 1'b1;
    cyc(DEB - 1);
    chk("R3 not settled before count", stable, 1'b0);
    cyc(1);
    chk("R5 stable with no card", stable, 1'b1);
    chk("R5 no card inserted", inserted, 1'b0);
    chk("R1 absent level", raw_present, 1'b0);
  endtask

  task automatic t_wp;
    wp_pin = 1'b0; #1;
    chk("R11 protected", wp_level, 1'b0);
    wp_pin = 1'b1; #1;
    chk("R11 enabled", wp_level, 1'b1);
  endtask

  task automatic t_insert;
    en_sts_ins = 1'b1; en_irq_ins = 1'b1;
    cd_pin_n = 1'b0;
    cyc(1);
    chk("R1 raw not yet", raw_present, 1'b0);
    cyc(1);
    chk("R1 raw present", raw_present, 1'b1);
    cyc(1);
    chk("R4 stable dropped", stable, 1'b0);
    cyc(DEB - 1);
    chk("R3 still counting", stable, 1'b0);
    chk("R3 inserted held", inserted, 1'b0);
    cyc(1);
    chk("R3 settled", stable, 1'b1);
    chk("R5 card present", inserted, 1'b1);
    chk("R6 flag not early", sts_ins, 1'b0);
    cyc(1);
    chk("R6 insertion flag", sts_ins, 1'b1);
    chk("R9 irq on insertion", irq, 1'b1);
    cyc(5);
    chk("R8 sticky", sts_ins, 1'b1);
    clr_ins = 1'b1; cyc(1); clr_ins = 1'b0;
    chk("R8 cleared", sts_ins, 1'b0);
    chk("R9 irq gone", irq, 1'b0);
  endtask

  task automatic t_glitch;
    en_sts_rem = 1'b1;
    cd_pin_n = 1'b1; cyc(1); cd_pin_n = 1'b0;
    cyc(2);
    chk("R4 glitch drops stable", stable, 1'b0);
    cyc(DEB + 6);
    chk("R4 resettled", stable, 1'b1);
    chk("R4 inserted kept", inserted, 1'b1);
    chk("R4 no removal event", sts_rem, 1'b0);
    chk("R4 no insertion event", sts_ins, 1'b0);
  endtask

  task automatic t_remove_disabled;
    en_sts_rem = 1'b0;
    cd_pin_n = 1'b1;
    cyc(3 + DEB);
    chk("R5 removed", inserted, 1'b0);
    chk("R5 stable after removal", stable, 1'b1);
    cyc(2);
    chk("R7 disabled no flag", sts_rem, 1'b0);
  endtask

  task automatic t_irq_mask;
    en_sts_ins = 1'b1; en_irq_ins = 1'b0;
    cd_pin_n = 1'b0;
    cyc(4 + DEB);
    chk("R6 flag set", sts_ins, 1'b1);
    chk("R9 masked", irq, 1'b0);
    en_irq_ins = 1'b1; #1;
    chk("R9 unmasked", irq, 1'b1);
    cyc(1);
    clr_ins = 1'b1; cyc(1); clr_ins = 1'b0;
    chk("R8 clear ins", sts_ins, 1'b0);
  endtask

  task automatic t_set_wins;
    en_sts_rem = 1'b1; en_irq_rem = 1'b1;
    cd_pin_n = 1'b1;
    cyc(3 + DEB);
    chk("R5 removed", inserted, 1'b0);
    clr_rem = 1'b1; cyc(1); clr_rem = 1'b0;
    chk("R8 set wins", sts_rem, 1'b1);
    chk("R9 irq removal", irq, 1'b1);
    clr_rem = 1'b1; cyc(1); clr_rem = 1'b0;
    chk("R8 clear rem", sts_rem, 1'b0);
  endtask

  task automatic t_tick_gate;
    en_sts_ins = 1'b0;
    deb_tick = 1'b0;
    cd_pin_n = 1'b0;
    cyc(3 + DEB + 10);
    chk("R3 no tick no settle", stable, 1'b0);
    chk("R3 no tick inserted", inserted, 1'b0);
    deb_tick = 1'b1;
    cyc(DEB - 1);
    chk("R3 tick count short", stable, 1'b0);
    cyc(1);
    chk("R3 tick count done", inserted, 1'b1);
    cyc(1);
    chk("R6 disabled no flag", sts_ins, 1'b0);
  endtask

  task automatic t_swrst;
    en_sts_rem = 1'b1;
    cd_pin_n = 1'b1;
    cyc(3);
    sw_rst = 1'b1; cyc(1); sw_rst = 1'b0;
    cyc(DEB - 2);
    chk("R10 count intact short", stable, 1'b0);
    cyc(1);
    chk("R10 settles on time", stable, 1'b1);
    chk("R10 removed", inserted, 1'b0);
    cyc(1);
    chk("R7 removal flag", sts_rem, 1'b1);
    sw_rst = 1'b1; cyc(1); sw_rst = 1'b0;
    chk("R10 flag cleared", sts_rem, 1'b0);
    chk("R10 stable kept", stable, 1'b1);
    chk("R10 inserted kept", inserted, 1'b0);
  endtask

  initial begin
    t_reset();
    t_wp();
    t_insert();
    t_glitch();
    t_remove_disabled();
    t_irq_mask();
    t_set_wins();
    t_tick_gate();
    t_swrst();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule